// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the word a flash device returns on a read while an embedded program or erase runs. The command sequencer supplies the operation state: busy, operation kind, suspend, whether the erase window has closed, a time-limit flag and bit 7 of the word being programmed. The block watches the read strobe and the sector being read. While an operation is active it drives a status byte in place of array data. The byte carries a polling bit, two toggle bits, a failure bit and a window bit.

The two toggle bits are the only state. Each flips once per rising edge of the read strobe, under its own enable condition. Software reads the byte twice and compares the results. From that it can tell a running operation, a suspended erase, a failed operation and a finished one apart. Once the operation ends, or when a suspended erase is read outside the sectors being erased, array data is returned unchanged.

Top module: `emb_status_gen`

## Requirements
- R1: When no operation is active (busy=0, suspended=0), the output is the array data. In byte mode (word_mode=0) the output is {8'h00, array_data[7:0]}. In word mode it is all 16 bits of array_data.
- R2: During a program (busy=1, op_erase=0, suspended=0), status bit 7 reads as the inverse of prog_bit7.
- R3: During an erase (busy=1, op_erase=1, suspended=0), status bit 7 reads 0. During a suspended-erase status read, bit 7 reads 1.
- R4: Status bit 6 flips once per rising edge of rd_stb while busy=1 and suspended=0. A strobe held high for many cycles gives one flip. With the strobe low, bit 6 does not change.
- R5: While busy=1 and suspended=0, status bit 5 equals time_exceeded. In every status read, bits 4, 1 and 0 read 0.
- R6: Status bit 3 equals window_closed when op_erase=1 and reads 0 when op_erase=0.
- R7: Status bit 2 flips once per rising edge of rd_stb when the sector read (rd_sector) has its bit set in erase_mask, op_erase=1, and either busy or suspended is 1. Reads of any other sector leave bit 2 unchanged.
- R8: While suspended=1, a read of a sector set in erase_mask returns the status byte with bit 6 frozen. A read of any other sector returns array data, and neither toggle bit changes.
- R9: In word mode the upper byte of a status read equals the lower byte.
- R10: Synchronous reset clears both toggle bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Output-enabled read strobe |
| rd_sector | input | SECT_W | Sector index of the read address |
| erase_mask | input | NUM_SECT | Sectors selected for erase |
| busy | input | 1 | Embedded operation running |
| op_erase | input | 1 | 1 = erase, 0 = program |
| suspended | input | 1 | Erase suspended |
| window_closed | input | 1 | Sector erase window has closed |
| time_exceeded | input | 1 | Internal time limit exceeded |
| prog_bit7 | input | 1 | Bit 7 of the data being programmed |
| array_data | input | DATA_W | Data from the array |
| word_mode | input | 1 | 1 = word reads, 0 = byte reads |
| status_out | output | DATA_W | Read data toward the bus |

## Verification
The bench builds the block with its default parameters: eleven sectors, a 4-bit sector index and a 16-bit data path. At this size one erase mask can mark some sectors selected and others not. This lets the bench compare reads of selected and unselected sectors during erase and during suspend. The 16-bit width brings the upper-byte mirror of word mode within reach. The bench tracks both toggle bits read by read across program, erase, suspend, timeout and reset.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

    typedef struct packed {
        logic poll;      // bit 7
        logic tog_op;    // bit 6
        logic tmo;       // bit 5
        logic rsv4;      // bit 4
        logic window;    // bit 3
        logic tog_sect;  // bit 2
        logic rsv1;      // bit 1
        logic rsv0;      // bit 0
    } stat_byte_t;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_ACTIVE = 2'd1,
        SRC_SUSP   = 2'd2
    } rd_src_t;

    function automatic logic [15:0] widen(input logic [7:0] b, input logic mirror);
        return mirror ? {b, b} : {8'h00, b};
    endfunction

endpackage

// File: rtl/rd_rise_det.sv
module rd_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb;
    end

    assign rise = stb & ~stb_q;
endmodule

// File: rtl/toggle_cell.sv
module toggle_cell (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic en,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (step && en) q <= ~q;
    end
endmodule

// File: rtl/status_fmt.sv
module status_fmt
    import emb_status_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rd_src_t           src,
    input  logic              op_erase,
    input  logic              prog_bit7,
    input  logic              window_closed,
    input  logic              time_exceeded,
    input  logic              tog6,
    input  logic              tog2,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF = DATA_W / 2;
    stat_byte_t sb;

    always_comb begin
        sb          = '0;
        sb.tog_op   = tog6;
        sb.tog_sect = tog2;
        sb.window   = op_erase & window_closed;
        if (src == SRC_SUSP) begin
            sb.poll = 1'b1;
        end else begin
            sb.poll = op_erase ? 1'b0 : ~prog_bit7;
            sb.tmo  = time_exceeded;
        end
    end

    always_comb begin
        if (src == SRC_ARRAY) begin
            dout = word_mode ? array_data
                             : {{(DATA_W-HALF){1'b0}}, array_data[HALF-1:0]};
        end else begin
            dout = DATA_W'(widen(sb, word_mode));
        end
    end
endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
    import emb_status_pkg::*;
#(
    parameter int NUM_SECT = 11,
    parameter int DATA_W   = 16,
    parameter int SECT_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  logic [SECT_W-1:0]   rd_sector,
    input  logic [NUM_SECT-1:0] erase_mask,
    input  logic                busy,
    input  logic                op_erase,
    input  logic                suspended,
    input  logic                window_closed,
    input  logic                time_exceeded,
    input  logic                prog_bit7,
    input  logic [DATA_W-1:0]   array_data,
    input  logic                word_mode,
    output logic [DATA_W-1:0]   status_out
);
    logic    rd_rise;
    logic    sect_hit;
    logic    tog6_q;
    logic    tog2_q;
    logic    en6;
    logic    en2;
    rd_src_t src;

    always_comb begin
        sect_hit = 1'b0;
        if (int'(rd_sector) < NUM_SECT) sect_hit = erase_mask[rd_sector];
    end

    always_comb begin
        if (suspended)  src = sect_hit ? SRC_SUSP : SRC_ARRAY;
        else if (busy)  src = SRC_ACTIVE;
        else            src = SRC_ARRAY;
    end

    assign en6 = busy & ~suspended;
    assign en2 = op_erase & sect_hit & (busy | suspended);

    rd_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .stb  (rd_stb),
        .rise (rd_rise)
    );

    toggle_cell u_tog6 (
        .clk  (clk),
        .rst  (rst),
        .step (rd_rise),
        .en   (en6),
        .q    (tog6_q)
    );

    toggle_cell u_tog2 (
        .clk  (clk),
        .rst  (rst),
        .step (rd_rise),
        .en   (en2),
        .q    (tog2_q)
    );

    status_fmt #(.DATA_W(DATA_W)) u_fmt (
        .src           (src),
        .op_erase      (op_erase),
        .prog_bit7     (prog_bit7),
        .window_closed (window_closed),
        .time_exceeded (time_exceeded),
        .tog6          (tog6_q),
        .tog2          (tog2_q),
        .word_mode     (word_mode),
        .array_data    (array_data),
        .dout          (status_out)
    );
endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic              busy,
    input logic              op_erase,
    input logic              suspended,
    input logic              time_exceeded,
    input logic              prog_bit7,
    input logic              word_mode,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] status_out,
    input logic              tog6,
    input logic              tog2
);
    localparam int HALF = DATA_W / 2;

    assert_idle_array_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !suspended && !word_mode) |-> status_out == {{(DATA_W-HALF){1'b0}}, array_data[HALF-1:0]});

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !suspended && !op_erase) |-> status_out[7] == ~prog_bit7);

    assert_erase_poll_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !suspended && op_erase) |-> status_out[7] == 1'b0);

    assert_no_strobe_tog6_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(tog6));

    assert_held_strobe_tog6_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && $past(rd_stb)) |=> $stable(tog6));

    assert_timeout_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !suspended) |-> status_out[5] == time_exceeded);

    assert_no_strobe_tog2_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(tog2));

    assert_susp_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (suspended && !busy) |=> $stable(tog6));

    assert_word_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !suspended && word_mode) |-> status_out[DATA_W-1:HALF] == status_out[HALF-1:0]);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!tog6 && !tog2));
endmodule

bind emb_status_gen emb_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_stb        (rd_stb),
    .busy          (busy),
    .op_erase      (op_erase),
    .suspended     (suspended),
    .time_exceeded (time_exceeded),
    .prog_bit7     (prog_bit7),
    .word_mode     (word_mode),
    .array_data    (array_data),
    .status_out    (status_out),
    .tog6          (tog6_q),
    .tog2          (tog2_q)
);

// File: tb/emb_status_gen_tb_top.sv
module emb_status_gen_tb_top;
    localparam int NUM_SECT = 11;
    localparam int DATA_W   = 16;
    localparam int SECT_W   = 4;
    localparam int NVEC     = 15;

    // {busy, erase, susp, closed, tmo, pbit7, sector[3:0], expected low byte}
    localparam logic [17:0] VEC [NVEC] = '{
        {6'b000000, 4'd0, 8'h3C},   // R1 idle
        {6'b100001, 4'd0, 8'h00},   // R2 program, bit7 inverted
        {6'b100001, 4'd0, 8'h40},   // R4 bit6 flipped
        {6'b100000, 4'd0, 8'h80},   // R2
        {6'b100010, 4'd0, 8'hE0},   // R5 timeout
        {6'b110000, 4'd0, 8'h00},   // R3 R6 window open
        {6'b110100, 4'd0, 8'h48},   // R6 window closed
        {6'b110100, 4'd1, 8'h08},   // R7 selected sector
        {6'b110100, 4'd2, 8'h4C},   // R7 bit2 flipped
        {6'b011100, 4'd1, 8'h88},   // R3 R8 suspend read
        {6'b011100, 4'd1, 8'h8C},   // R8 bit6 frozen, R7 bit2 flips
        {6'b011100, 4'd5, 8'h3C},   // R8 other sector -> array
        {6'b010100, 4'd0, 8'h3C},   // R1 done
        {6'b110110, 4'd0, 8'h28},   // R5 erase timeout
        {6'b110110, 4'd0, 8'h68}    // R5 bit6 keeps flipping
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                rd_stb = 1'b0;
    logic [SECT_W-1:0]   rd_sector = '0;
    logic [NUM_SECT-1:0] erase_mask = 11'b000_0000_0110;
    logic                busy = 1'b0;
    logic                op_erase = 1'b0;
    logic                suspended = 1'b0;
    logic                window_closed = 1'b0;
    logic                time_exceeded = 1'b0;
    logic                prog_bit7 = 1'b0;
    logic [DATA_W-1:0]   array_data = 16'h5A3C;
    logic                word_mode = 1'b0;
    logic [DATA_W-1:0]   status_out;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    emb_status_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .rd_stb        (rd_stb),
        .rd_sector     (rd_sector),
        .erase_mask    (erase_mask),
        .busy          (busy),
        .op_erase      (op_erase),
        .suspended     (suspended),
        .window_closed (window_closed),
        .time_exceeded (time_exceeded),
        .prog_bit7     (prog_bit7),
        .array_data    (array_data),
        .word_mode     (word_mode),
        .status_out    (status_out)
    );

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (status_out !== exp) begin
            n_errors++;
            $display("FAIL %s: status_out=%h expected=%h", req, status_out, exp);
        end
    endtask

    task automatic set_in(input logic [17:0] v);
        @(negedge clk);
        busy          = v[17];
        op_erase      = v[16];
        suspended     = v[15];
        window_closed = v[14];
        time_exceeded = v[13];
        prog_bit7     = v[12];
        rd_sector     = v[11:8];
        #1;
    endtask

    task automatic pulse_rd(input int hold);
        @(negedge clk);
        rd_stb = 1'b1;
        for (int k = 0; k < hold; k++) @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: run hung");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 R10 reset idle", 16'h003C);

        for (int i = 0; i < NVEC; i++) begin
            set_in(VEC[i]);
            check($sformatf("vector %0d R1-R8", i), {8'h00, VEC[i][7:0]});
            pulse_rd(1);
        end

        // toggles now both 0; word mode erase
        word_mode = 1'b1;
        set_in({6'b110100, 4'd0, 8'h00});
        check("R9 word mirror", 16'h0808);
        pulse_rd(1);
        set_in({6'b110100, 4'd0, 8'h00});
        check("R9 R4 word mirror after flip", 16'h4848);
        pulse_rd(6);
        #1;
        check("R4 held strobe single flip", 16'h0808);

        set_in({6'b000000, 4'd0, 8'h00});
        check("R1 word array", 16'h5A3C);

        word_mode = 1'b0;
        set_in({6'b110100, 4'd0, 8'h00});
        pulse_rd(1);
        #1;
        check("R4 pre-reset flip", 16'h0048);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset clears toggle", 16'h0008);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule